// File: doc/BRIEF.md
# Byte-at-a-time SPI master

This block is a bus-attached SPI master that moves one 8-bit word per software command and keeps no queue. Software loads a transmit byte, sets the start bit in the control register, and waits for the interrupt. The engine then drives sixteen serial clock edges, shifting the byte out on `mosi` while it collects one from `miso`. When the byte is done, the received byte lands in the receive register, the ready flag and `irq` go high, and software reads the byte before it starts the next one.

Byte-wide registers set the serial clock divisor, the clock polarity, the sampling phase, the bit order and an internal loopback path. The serial clock runs at the bus clock divided by 4×(divisor+1). Chip selects are driven outside this block. Register offsets: 0 mode, 1 receive data, 2 transmit data, 3 control, 4 status, 5 reserved (reads zero), 6 clock divisor.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low and `sck` is low. The mode register (offset 0), transmit register (offset 2) and divisor register (offset 6) read back what was last written. Offset 5 reads 0x00.
- R2: Each half period of `sck` lasts 2×(D+1) bus clocks, where D is the divisor value. The ready flag becomes visible exactly 32×(D+1) clocks after the clock edge that accepts the start command.
- R3: Mode bit 0x02 sets the idle level of `sck` (1 means idle high). Whenever no transfer is in progress, `sck` sits at that idle level.
- R4: Mode bit 0x10 selects the sampling phase. When it is 1, the first bit is on `mosi` before the first clock edge, and both sides sample on the leading edges. When it is 0, data changes on the leading edges and is sampled on the trailing edges.
- R5: Mode bit 0x04 selects least-significant-bit-first order for both directions. When it is 0, the most significant bit goes first.
- R6: Mode bit 0x01 enables loopback. `mosi` is fed back internally as the serial input, the `miso` pin is ignored, and the received byte equals the transmitted byte.
- R7: Writing the control register (offset 3) with bit 0x01 set starts a transfer, but only when mode bit 0x08 (enable) is 1 and no transfer is in progress. Otherwise the write is ignored.
- R8: Status register (offset 4): bit 0x02 is busy and bit 0x01 is receive-ready. In the first cycle that receive-ready is set, busy still reads 1. Busy clears on the following cycle.
- R9: `irq` is high exactly while receive-ready is set. A read of the receive register (offset 1) clears both.
- R10: Writing the transmit register or the start bit during a transfer does not change the byte that is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of the receive register clears the ready flag) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Byte-complete interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is the single cycle in which receive-ready is already set and busy has not yet dropped. The bench counts clocks from the start write until `irq` first appears. In that same cycle it raises a status read, so the 0x03 value is captured before the next edge clears busy. A second hard case is a start or transmit write that arrives in the middle of a shift. The bench injects these writes at fixed cycle counts inside the wait loop and then checks the bits captured by its own serial slave model.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

   localparam logic [2:0] OFS_MODE = 3'd0;
   localparam logic [2:0] OFS_RXD  = 3'd1;
   localparam logic [2:0] OFS_TXD  = 3'd2;
   localparam logic [2:0] OFS_CTRL = 3'd3;
   localparam logic [2:0] OFS_STAT = 3'd4;
   localparam logic [2:0] OFS_DIV  = 3'd6;

   // Mode register fields; the packed order fixes the bit positions
   // software relies on (lead=0x10, en=0x08, lsb=0x04, idle_hi=0x02, loop=0x01).
   typedef struct packed {
      logic lead;
      logic en;
      logic lsb;
      logic idle_hi;
      logic loop;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RUN  = 2'd1,
      ENG_DONE = 2'd2
   } eng_state_t;

endpackage

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // half period = 2*(div+1) clocks, so the count ends at 2*div+1
   assign limit = {div, 1'b1};
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || tick)    cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_byte_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              lead,
   input  logic              lsb_first,
   input  logic              idle_hi,
   input  logic              loopback,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   input  logic              tick,
   output logic              busy,
   output logic              run,
   output logic              done_set,
   output logic [WORD_W-1:0] rx_word,
   output logic              sck,
   output logic              mosi
);
   localparam int EDGES  = 2 * WORD_W;
   localparam int ECNT_W = $clog2(EDGES);
   localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);

   eng_state_t        state_q;
   logic [ECNT_W-1:0] edge_q;
   logic              phase_q;
   logic [WORD_W-1:0] tx_sr_q;
   logic [WORD_W-1:0] rx_sr_q;

   logic [WORD_W-1:0] tx_rev, tx_ordered;
   logic [WORD_W-1:0] rx_next, rx_final, rx_rev;
   logic              cpha, din, sample_edge, shift_edge, last_edge;

   genvar gi;
   generate
      for (gi = 0; gi < WORD_W; gi++) begin : g_rev
         assign tx_rev[gi] = tx_word[WORD_W-1-gi];
         assign rx_rev[gi] = rx_final[WORD_W-1-gi];
      end
   endgenerate

   assign tx_ordered  = lsb_first ? tx_rev : tx_word;
   assign cpha        = ~lead;
   assign mosi        = tx_sr_q[WORD_W-1];
   assign din         = loopback ? mosi : miso;
   assign sample_edge = tick && (edge_q[0] == cpha);
   assign shift_edge  = tick && (edge_q[0] != cpha) && !(cpha && edge_q == '0);
   assign last_edge   = tick && (edge_q == LAST_EDGE);
   assign rx_next     = {rx_sr_q[WORD_W-2:0], din};
   assign rx_final    = sample_edge ? rx_next : rx_sr_q;
   assign rx_word     = lsb_first ? rx_rev : rx_final;

   assign busy     = (state_q != ENG_IDLE);
   assign run      = (state_q == ENG_RUN);
   assign done_set = run && last_edge;
   assign sck      = idle_hi ^ phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         edge_q  <= '0;
         phase_q <= 1'b0;
         tx_sr_q <= '0;
         rx_sr_q <= '0;
      end else if (!enable) begin
         state_q <= ENG_IDLE;
         edge_q  <= '0;
         phase_q <= 1'b0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  tx_sr_q <= tx_ordered;
                  rx_sr_q <= '0;
                  edge_q  <= '0;
                  phase_q <= 1'b0;
                  state_q <= ENG_RUN;
               end
            end
            ENG_RUN: begin
               if (tick) begin
                  phase_q <= ~phase_q;
                  edge_q  <= edge_q + 1'b1;
                  if (sample_edge) rx_sr_q <= rx_next;
                  if (shift_edge)  tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
                  if (last_edge)   state_q <= ENG_DONE;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
   import spi_byte_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              done_set,
   input  logic [DATA_W-1:0] rx_word,
   output mode_t             mode,
   output logic [DATA_W-1:0] tx_byte,
   output logic [DIV_W-1:0]  div,
   output logic              start,
   output logic              irq
);
   mode_t             mode_q;
   logic [DATA_W-1:0] tx_q, rx_q;
   logic [DIV_W-1:0]  div_q;
   logic              rdy_q;
   logic              sel_mode, sel_txd, sel_ctrl, sel_div, sel_rxd;

   assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
   assign sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_div  = (bus_addr == ADDR_W'(OFS_DIV));

   assign start   = bus_wr && sel_ctrl && bus_wdata[0] && mode_q.en && !busy;
   assign mode    = mode_q;
   assign tx_byte = tx_q;
   assign div     = div_q;
   assign irq     = rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         tx_q   <= '0;
         div_q  <= '0;
      end else if (bus_wr) begin
         if (sel_mode) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
         if (sel_txd)  tx_q   <= bus_wdata;
         if (sel_div)  div_q  <= bus_wdata[DIV_W-1:0];
      end
   end

   // a completing byte wins over a same-cycle read of the receive register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= '0;
         rdy_q <= 1'b0;
      end else if (done_set) begin
         rx_q  <= rx_word;
         rdy_q <= 1'b1;
      end else if (bus_rd && sel_rxd) begin
         rdy_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_MODE): bus_rdata = DATA_W'(mode_q);
         ADDR_W'(OFS_RXD):  bus_rdata = rx_q;
         ADDR_W'(OFS_TXD):  bus_rdata = tx_q;
         ADDR_W'(OFS_STAT): bus_rdata = DATA_W'({busy, rdy_q});
         ADDR_W'(OFS_DIV):  bus_rdata = DATA_W'(div_q);
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_byte_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   generate
      if (DATA_W < MODE_W) begin : g_bad_data_w
         $error("DATA_W too narrow for the mode register");
      end
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("ADDR_W cannot reach every register offset");
      end
      if (DIV_W > DATA_W || DIV_W < 1) begin : g_bad_div_w
         $error("DIV_W must be between 1 and DATA_W");
      end
   endgenerate

   mode_t             mode_q;
   logic [DATA_W-1:0] tx_byte, rx_word;
   logic [DIV_W-1:0]  div_q;
   logic              start, eng_busy, eng_run, done_set, pre_tick;
   logic              mode_en, mode_idle_hi;

   assign mode_en      = mode_q.en;
   assign mode_idle_hi = mode_q.idle_hi;

   spi_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(eng_busy), .done_set(done_set), .rx_word(rx_word),
      .mode(mode_q), .tx_byte(tx_byte), .div(div_q),
      .start(start), .irq(irq)
   );

   spi_clk_prescaler #(.DIV_W(DIV_W)) i_presc (
      .clk(clk), .rst_n(rst_n), .run(eng_run), .div(div_q), .tick(pre_tick)
   );

   spi_shift_engine #(.WORD_W(DATA_W)) i_eng (
      .clk(clk), .rst_n(rst_n),
      .enable(mode_en), .lead(mode_q.lead), .lsb_first(mode_q.lsb),
      .idle_hi(mode_idle_hi), .loopback(mode_q.loop),
      .start(start), .tx_word(tx_byte), .miso(miso), .tick(pre_tick),
      .busy(eng_busy), .run(eng_run), .done_set(done_set),
      .rx_word(rx_word), .sck(sck), .mosi(mosi)
   );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
   import spi_byte_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              sck,
   input logic              irq,
   input logic              busy,
   input logic              tick,
   input logic              done_set,
   input logic              en,
   input logic              idle_hi
);
   assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == idle_hi));

   assert_sck_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> $stable(sck));

   assert_bsy_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> busy);

   assert_bsy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |=> !busy);

   assert_no_start_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[0] && !en && !busy) |=> !busy);

   assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_RXD) && !done_set) |=> !irq);
endmodule

bind spi_byte_master spi_byte_master_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sck(sck), .irq(irq),
   .busy(eng_busy), .tick(pre_tick), .done_set(done_set),
   .en(mode_en), .idle_hi(mode_idle_hi)
);

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq, sck, mosi;
   logic       miso = 1'b0;

   int n_checks = 0;
   int n_errs   = 0;

   // serial slave model
   logic       sl_on = 1'b0, sl_cpol = 1'b0, sl_lead = 1'b0, sl_lsb = 1'b0;
   logic [7:0] sl_byte = '0, cap = '0;
   int         sl_idx = 0;

   always #10 clk = ~clk;

   spi_byte_master i_spi_byte_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
   );

   function automatic logic sl_bit(input int k);
      if (k > 7) return 1'b0;
      return sl_lsb ? sl_byte[k] : sl_byte[7-k];
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   always @(sck) begin
      if (sl_on) begin
         if ((sck !== sl_cpol) == sl_lead) cap = {cap[6:0], mosi};
         else begin
            miso = sl_bit(sl_idx);
            sl_idx = sl_idx + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R1 irq after reset", irq, 0);
      check("R1 sck after reset", sck, 0);
      bus_read(3'd0, v); check("R1 mode reset", v, 8'h00);
      bus_read(3'd2, v); check("R1 txd reset", v, 8'h00);
      bus_read(3'd4, v); check("R1 status reset", v, 8'h00);
      bus_read(3'd6, v); check("R1 divisor reset", v, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      bus_write(3'd6, 8'h5A); bus_read(3'd6, v); check("R1 divisor readback", v, 8'h5A);
      bus_write(3'd2, 8'h96); bus_read(3'd2, v); check("R1 txd readback", v, 8'h96);
      bus_write(3'd0, 8'h17); bus_read(3'd0, v); check("R1 mode readback", v, 8'h17);
      bus_read(3'd5, v); check("R1 reserved reads zero", v, 8'h00);
      bus_write(3'd0, 8'h00);
      bus_write(3'd6, 8'h00);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      bus_write(3'd0, 8'h02);
      check("R3 idle high while disabled", sck, 1);
      bus_write(3'd2, 8'h55);
      bus_write(3'd3, 8'h01);
      repeat (40) @(negedge clk);
      bus_read(3'd4, v); check("R7 start ignored when disabled", v, 8'h00);
      check("R7 no irq when disabled", irq, 0);
      check("R3 sck stays idle", sck, 1);
      bus_write(3'd0, 8'h00);
      check("R3 idle low", sck, 0);
   endtask

   // one full byte; meddle injects a TXD write and a second start mid-transfer
   task automatic t_xfer(input string tag, input logic [7:0] mode, input logic [7:0] tx,
                         input logic [7:0] sl, input logic [7:0] div,
                         input logic [7:0] exp_rx, input bit meddle);
      int cyc;
      int exp_cyc;
      bus_write(3'd6, div);
      bus_write(3'd0, mode);
      bus_write(3'd2, tx);
      sl_cpol = mode[1]; sl_lead = mode[4]; sl_lsb = mode[2];
      sl_byte = sl; cap = '0;
      if (sl_lead) begin miso = sl_bit(0); sl_idx = 1; end
      else sl_idx = 0;
      sl_on = 1'b1;
      bus_write(3'd3, 8'h01);
      cyc = 0;
      exp_cyc = 32 * (int'(div) + 1);
      while (irq !== 1'b1 && cyc < 40000) begin
         @(negedge clk);
         cyc++;
         if (meddle) begin
            if (cyc == 10) begin bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h00; end
            if (cyc == 11) begin bus_addr = 3'd3; bus_wdata = 8'h01; end
            if (cyc == 12) bus_wr = 1'b0;
         end
      end
      check({"R2 byte duration ", tag}, cyc, exp_cyc);
      bus_rd = 1'b1; bus_addr = 3'd4;
      #1 check({"R8 busy still set with ready ", tag}, bus_rdata, 8'h03);
      @(negedge clk);
      #1 check({"R8 busy cleared next cycle ", tag}, bus_rdata, 8'h01);
      bus_addr = 3'd1;
      #1 check({"rx byte ", tag}, bus_rdata, exp_rx);
      @(negedge clk);
      bus_rd = 1'b0;
      #1 check({"R9 irq cleared by rx read ", tag}, irq, 0);
      sl_on = 1'b0;
      check({"mosi byte ", tag}, sl_lsb ? rev8(cap) : cap, tx);
      check({"R3 sck back at idle ", tag}, sck, mode[1]);
   endtask

   task automatic t_no_restart;
      logic [7:0] v;
      t_xfer("R10 R7 mid-transfer writes", 8'h18, 8'hC3, 8'h99, 8'h00, 8'h99, 1'b1);
      repeat (200) @(negedge clk);
      bus_read(3'd4, v); check("R7 second start while busy ignored", v, 8'h00);
      check("R7 no extra irq", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_disabled();
      t_xfer("R4 lead phase msb", 8'h18, 8'hA5, 8'h3C, 8'h00, 8'h3C, 1'b0);
      t_xfer("R4 trail phase msb", 8'h08, 8'h5A, 8'hC3, 8'h00, 8'hC3, 1'b0);
      t_xfer("R3 R4 idle high lead", 8'h1A, 8'h81, 8'h7E, 8'h00, 8'h7E, 1'b0);
      t_xfer("R3 R4 idle high trail", 8'h0A, 8'h0F, 8'hF0, 8'h00, 8'hF0, 1'b0);
      t_xfer("R5 lsb first lead", 8'h1C, 8'h01, 8'h80, 8'h00, 8'h80, 1'b0);
      t_xfer("R5 lsb first trail", 8'h0E, 8'hD2, 8'h4B, 8'h00, 8'h4B, 1'b0);
      t_xfer("R6 loopback", 8'h19, 8'hA5, 8'h5A, 8'h00, 8'hA5, 1'b0);
      t_xfer("R6 loopback lsb trail", 8'h0D, 8'h3E, 8'hC1, 8'h01, 8'h3E, 1'b0);
      t_xfer("R2 divisor 3", 8'h18, 8'h6C, 8'h93, 8'h03, 8'h93, 1'b0);
      t_xfer("R2 divisor max", 8'h08, 8'hE7, 8'h18, 8'hFF, 8'h18, 1'b0);
      t_no_restart();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule